// File: doc/BRIEF.md
# PCI Host Bridge Register Interface

This block is the register front end of a PCI host bridge. A processor reaches it over a word-wide request/acknowledge bus. The bus gives access to a local 256-byte configuration header, to three bridge registers and to a data port. The configuration address register selects the target of downstream configuration cycles. The memory base and I/O base registers keep only some of their bits on a write. Each access to the data port becomes exactly one configuration cycle on a downstream request/acknowledge master port. The processor is not acknowledged until that cycle completes.

Two pieces of glue are also included. The first is a combinational translator for a 256 KiB I/O window, whose base is taken from the I/O base register. The second is a level-following interrupt router that drives output n from the device in slot n.

Top module: `pcib_regif`

## Requirements
- R1: Byte offsets 0x000 to 0x0FC (with address bits 1:0 equal to 00) address the 64 words of the local configuration header. A write stores all 32 bits, and a read returns the stored word.
- R2: After reset, the header word at 0x004 reads 0x02900080. Its low half is the command word with only bit 7 set. Its high half is the status word with bits 4, 7 and 9 set. Every other header word reads 0.
- R3: Offset 0x1C0 is the configuration address register. It reads 0 after reset, and all 32 written bits read back.
- R4: Offset 0x1C4 is the memory base register. It reads 0 after reset, and a write stores the written value AND 0xFF000001.
- R5: Offset 0x1C8 is the I/O base register. It reads 0 after reset, and a write stores the written value AND 0xFFFC0001.
- R6: The I/O translator outputs io_addr_o = (I/O base AND 0xFFFC0000) + io_win_off_i, where the window offset is 18 bits wide. The output is combinational and follows a new base from the cycle after the write's acknowledge.
- R7: A write to offset 0x220 issues one configuration cycle. It has cfg_we_o=1, cfg_addr_o equal to the configuration address register, and cfg_wdata_o equal to the written data. cpu_ack_o rises in the cycle after the cycle in which cfg_ack_i is seen, so with a responder delay of d cycles the acknowledge comes 2+d cycles after the request.
- R8: A read of offset 0x220 issues one configuration cycle with cfg_we_o=0 at the configuration address. It returns the cfg_rdata_i value presented with cfg_ack_i.
- R9: Reads of offsets outside the map, or with address bits 1:0 not equal to 00, return 0. Writes to them change no register. The map covers the header, 0x1C0, 0x1C4, 0x1C8 and 0x220.
- R10: An access to any location other than the data port is acknowledged one cycle after the request. cpu_ack_o is always a single-cycle pulse.
- R11: irq_o[n] follows irq_i[n], the level from the device in slot n, for each of the four slots.
- R12: At most one configuration cycle is outstanding. cfg_req_o, cfg_addr_o, cfg_we_o and cfg_wdata_o stay stable until cfg_ack_i, and cpu_ack_o stays low while cfg_req_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until acknowledged |
| cpu_we_i | input | 1 | Processor write when 1, read when 0 |
| cpu_addr_i | input | 10 | Processor byte offset |
| cpu_wdata_i | input | 32 | Processor write data |
| cpu_ack_o | output | 1 | Single-cycle acknowledge |
| cpu_rdata_o | output | 32 | Read data, valid with cpu_ack_o |
| cfg_req_o | output | 1 | Downstream configuration cycle request |
| cfg_we_o | output | 1 | Downstream configuration write |
| cfg_addr_o | output | 32 | Downstream configuration address |
| cfg_wdata_o | output | 32 | Downstream configuration write data |
| cfg_ack_i | input | 1 | Downstream completion |
| cfg_rdata_i | input | 32 | Downstream read data, valid with cfg_ack_i |
| io_win_off_i | input | 18 | Offset inside the I/O window |
| io_addr_o | output | 32 | Translated downstream I/O address |
| irq_i | input | 4 | Interrupt level per device slot |
| irq_o | output | 4 | Routed interrupt outputs |

## Verification
The bench builds the block with its default parameters: a 10-bit offset bus, a 64-word header, an 18-bit I/O window and four interrupt slots. With these values every decoded offset can be reached, including the top header word at 0x0FC and the last offset 0x3FC of the address space. The window offset can span its full range from 0 to 0x3FFFF. The bench also varies the downstream responder delay, so the acknowledge latency of the data port can be checked both for an immediate completion and for a stalled one.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  localparam int unsigned DW = 32;
  localparam logic [9:0] OFF_PAR   = 10'h1C0;
  localparam logic [9:0] OFF_MBR   = 10'h1C4;
  localparam logic [9:0] OFF_IOBR  = 10'h1C8;
  localparam logic [9:0] OFF_DPORT = 10'h220;
  localparam logic [9:0] HDR_LAST  = 10'h0FC;
  localparam logic [DW-1:0] MBR_KEEP  = 32'hFF00_0001;
  localparam logic [DW-1:0] IOBR_KEEP = 32'hFFFC_0001;
  // command word: wait-cycle control; status: cap list, fast b2b, medium devsel
  localparam logic [DW-1:0] HDR_W1_RST = 32'h0290_0080;

  typedef enum logic [1:0] {ST_IDLE, ST_CFG, ST_RESP} fsm_e;
  typedef enum logic [2:0] {SEL_NONE, SEL_HDR, SEL_PAR, SEL_MBR, SEL_IOBR, SEL_DPORT} sel_e;

  function automatic logic [DW-1:0] hdr_rst(input int unsigned idx);
    return (idx == 1) ? HDR_W1_RST : '0;
  endfunction
endpackage

// File: rtl/pcib_cfg_hdr.sv
module pcib_cfg_hdr
  import pcib_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  localparam int unsigned IW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rd_arr [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= hdr_rst(w);
      else if (we_i && idx_i == IW'(w)) word_q <= wdata_i;
    end
    assign rd_arr[w] = word_q;
  end

  assign rdata_o = rd_arr[idx_i];
endmodule

// File: rtl/pcib_bridge_regs.sv
module pcib_bridge_regs
  import pcib_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          par_we_i,
  input  logic          mbr_we_i,
  input  logic          iobr_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] par_o,
  output logic [DW-1:0] mbr_o,
  output logic [DW-1:0] iobr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o  <= '0;
      mbr_o  <= '0;
      iobr_o <= '0;
    end else begin
      if (par_we_i)  par_o  <= wdata_i;
      if (mbr_we_i)  mbr_o  <= wdata_i & MBR_KEEP;
      if (iobr_we_i) iobr_o <= wdata_i & IOBR_KEEP;
    end
  end
endmodule

// File: rtl/pcib_io_xlate.sv
module pcib_io_xlate
  import pcib_pkg::*;
#(
  parameter int unsigned WIN_W = 18
) (
  input  logic [DW-1:0]    base_i,
  input  logic [WIN_W-1:0] off_i,
  output logic [DW-1:0]    addr_o
);
  // base is aligned to the window size, so the add reduces to a concat
  assign addr_o = {base_i[DW-1:WIN_W], off_i};
endmodule

// File: rtl/pcib_irq_route.sv
module pcib_irq_route #(
  parameter int unsigned N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_i,
  output logic [N_IRQ-1:0] irq_o
);
  for (genvar s = 0; s < N_IRQ; s++) begin : g_slot
    assign irq_o[s] = irq_i[s];
  end
endmodule

// File: rtl/pcib_regif.sv
module pcib_regif
  import pcib_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned HDR_WRDS = 64,
  parameter int unsigned WIN_W    = 18,
  parameter int unsigned N_IRQ    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DW-1:0]     cpu_rdata_o,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [DW-1:0]     cfg_addr_o,
  output logic [DW-1:0]     cfg_wdata_o,
  input  logic              cfg_ack_i,
  input  logic [DW-1:0]     cfg_rdata_i,
  input  logic [WIN_W-1:0]  io_win_off_i,
  output logic [DW-1:0]     io_addr_o,
  input  logic [N_IRQ-1:0]  irq_i,
  output logic [N_IRQ-1:0]  irq_o
);
  localparam int unsigned HIW = $clog2(HDR_WRDS);

  fsm_e          state_q;
  sel_e          sel;
  logic          accept;
  logic [DW-1:0] par_q, mbr_q, iobr_q, hdr_rd, local_rd;

  always_comb begin
    sel = SEL_NONE;
    if (cpu_addr_i[1:0] == 2'b00) begin
      if (cpu_addr_i <= ADDR_W'(HDR_LAST))        sel = SEL_HDR;
      else if (cpu_addr_i == ADDR_W'(OFF_PAR))    sel = SEL_PAR;
      else if (cpu_addr_i == ADDR_W'(OFF_MBR))    sel = SEL_MBR;
      else if (cpu_addr_i == ADDR_W'(OFF_IOBR))   sel = SEL_IOBR;
      else if (cpu_addr_i == ADDR_W'(OFF_DPORT))  sel = SEL_DPORT;
    end
  end

  assign accept = (state_q == ST_IDLE) && cpu_req_i;

  pcib_cfg_hdr #(.WORDS(HDR_WRDS)) u_hdr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (accept && cpu_we_i && sel == SEL_HDR),
    .idx_i   (cpu_addr_i[HIW+1:2]),
    .wdata_i (cpu_wdata_i),
    .rdata_o (hdr_rd)
  );

  pcib_bridge_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .par_we_i  (accept && cpu_we_i && sel == SEL_PAR),
    .mbr_we_i  (accept && cpu_we_i && sel == SEL_MBR),
    .iobr_we_i (accept && cpu_we_i && sel == SEL_IOBR),
    .wdata_i   (cpu_wdata_i),
    .par_o     (par_q),
    .mbr_o     (mbr_q),
    .iobr_o    (iobr_q)
  );

  pcib_io_xlate #(.WIN_W(WIN_W)) u_xlate (
    .base_i (iobr_q),
    .off_i  (io_win_off_i),
    .addr_o (io_addr_o)
  );

  pcib_irq_route #(.N_IRQ(N_IRQ)) u_irq (
    .irq_i (irq_i),
    .irq_o (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_HDR:  local_rd = hdr_rd;
      SEL_PAR:  local_rd = par_q;
      SEL_MBR:  local_rd = mbr_q;
      SEL_IOBR: local_rd = iobr_q;
      default:  local_rd = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cpu_ack_o   <= 1'b0;
      cpu_rdata_o <= '0;
      cfg_req_o   <= 1'b0;
      cfg_we_o    <= 1'b0;
      cfg_addr_o  <= '0;
      cfg_wdata_o <= '0;
    end else begin
      cpu_ack_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cpu_req_i) begin
          if (sel == SEL_DPORT) begin
            state_q     <= ST_CFG;
            cfg_req_o   <= 1'b1;
            cfg_we_o    <= cpu_we_i;
            cfg_addr_o  <= par_q;
            cfg_wdata_o <= cpu_wdata_i;
          end else begin
            state_q     <= ST_RESP;
            cpu_ack_o   <= 1'b1;
            cpu_rdata_o <= cpu_we_i ? '0 : local_rd;
          end
        end
        ST_CFG: if (cfg_ack_i) begin
          state_q     <= ST_RESP;
          cfg_req_o   <= 1'b0;
          cpu_ack_o   <= 1'b1;
          cpu_rdata_o <= cfg_we_o ? '0 : cfg_rdata_i;
        end
        // one idle cycle lets the requester drop its request after the ack
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcib_regif_chk.sv
module pcib_regif_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cpu_ack_o,
  input logic        cfg_req_o,
  input logic        cfg_ack_i,
  input logic        cfg_we_o,
  input logic [31:0] cfg_addr_o,
  input logic [31:0] cfg_wdata_o,
  input logic [31:0] par_q,
  input logic [31:0] mbr_q,
  input logic [31:0] iobr_q,
  input logic [31:0] io_addr_o
);
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o); // R10
  AST_NO_ACK_IN_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> !cpu_ack_o); // R12
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && !cfg_ack_i) |=> (cfg_req_o && $stable(cfg_addr_o) && $stable(cfg_we_o) && $stable(cfg_wdata_o))); // R12
  AST_CFG_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> cfg_addr_o == par_q); // R7
  AST_CFG_DONE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_req_o) |-> cpu_ack_o); // R7
  AST_MBR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbr_q & 32'h00FF_FFFE) == 32'h0); // R4
  AST_IOBR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iobr_q & 32'h0003_FFFE) == 32'h0); // R5
  AST_IO_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_addr_o[31:18] == iobr_q[31:18]); // R6
endmodule

bind pcib_regif pcib_regif_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_ack_o   (cpu_ack_o),
  .cfg_req_o   (cfg_req_o),
  .cfg_ack_i   (cfg_ack_i),
  .cfg_we_o    (cfg_we_o),
  .cfg_addr_o  (cfg_addr_o),
  .cfg_wdata_o (cfg_wdata_o),
  .par_q       (par_q),
  .mbr_q       (mbr_q),
  .iobr_q      (iobr_q),
  .io_addr_o   (io_addr_o)
);

// File: tb/pcib_regif_tb.sv
`timescale 1ns/1ps
module pcib_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [9:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        cfg_req, cfg_we;
  logic [31:0] cfg_addr, cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic [17:0] io_off = '0;
  logic [31:0] io_addr;
  logic [3:0]  irq_in = '0, irq_out;

  int errors = 0, checks = 0;
  int resp_dly = 0, wait_cnt = 0, cfg_count = 0;
  logic [31:0] resp_data = '0, cap_addr = '0, cap_wdata = '0;
  logic        cap_we = 1'b0;

  always #2.5 clk = ~clk;

  pcib_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_addr_o(cfg_addr), .cfg_wdata_o(cfg_wdata),
    .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata),
    .io_win_off_i(io_off), .io_addr_o(io_addr),
    .irq_i(irq_in), .irq_o(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // downstream responder
  initial forever begin
    @(negedge clk);
    if (cfg_ack) cfg_ack = 1'b0;
    else if (cfg_req) begin
      if (wait_cnt == resp_dly) begin
        cap_addr = cfg_addr; cap_we = cfg_we; cap_wdata = cfg_wdata;
        cfg_rdata = resp_data; cfg_ack = 1'b1; cfg_count++; wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  task automatic access(input logic we, input logic [9:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_ack && lat < 100);
    rd = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] rd; int lat;
    access(1'b1, a, d, rd, lat);
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] rd; int lat;
    access(1'b0, a, '0, rd, lat);
    chk(req, rd, exp);
    chk("R10 local latency", 32'(lat), 32'd1);
  endtask

  task automatic t_reset();
    rd_chk("R2 hdr word 0x004", 10'h004, 32'h0290_0080);
    rd_chk("R2 hdr word 0x000", 10'h000, 32'h0);
    rd_chk("R2 hdr word 0x0FC", 10'h0FC, 32'h0);
    rd_chk("R3 par reset", 10'h1C0, 32'h0);
    rd_chk("R4 mbr reset", 10'h1C4, 32'h0);
    rd_chk("R5 iobr reset", 10'h1C8, 32'h0);
    io_off = 18'h2_0004; #1;
    chk("R6 xlate at reset", io_addr, 32'h0002_0004);
  endtask

  task automatic t_header();
    wr(10'h000, 32'hDEAD_BEEF);
    wr(10'h0FC, 32'h0123_4567);
    wr(10'h004, 32'hFFFF_0000);
    rd_chk("R1 hdr 0x000", 10'h000, 32'hDEAD_BEEF);
    rd_chk("R1 hdr 0x0FC", 10'h0FC, 32'h0123_4567);
    rd_chk("R1 hdr 0x004", 10'h004, 32'hFFFF_0000);
    rd_chk("R1 hdr 0x008 untouched", 10'h008, 32'h0);
  endtask

  task automatic t_bridge_regs();
    wr(10'h1C0, 32'h8000_1234);
    rd_chk("R3 par readback", 10'h1C0, 32'h8000_1234);
    wr(10'h1C4, 32'hFFFF_FFFF);
    rd_chk("R4 mbr mask ones", 10'h1C4, 32'hFF00_0001);
    wr(10'h1C4, 32'h5A5A_5A5A);
    rd_chk("R4 mbr mask pattern", 10'h1C4, 32'h5A00_0000);
    wr(10'h1C8, 32'h1237_FFFF);
    rd_chk("R5 iobr mask", 10'h1C8, 32'h1234_0001);
  endtask

  task automatic t_xlate();
    io_off = 18'h3_FFFF; #1;
    chk("R6 xlate top of window", io_addr, 32'h1237_FFFF);
    io_off = 18'h0_0010; #1;
    chk("R6 xlate low offset", io_addr, 32'h1234_0010);
    wr(10'h1C8, 32'hFFFC_0000);
    #1;
    chk("R6 xlate new base", io_addr, 32'hFFFC_0010);
  endtask

  task automatic t_unmapped();
    wr(10'h100, 32'hAAAA_AAAA);
    rd_chk("R9 unmapped 0x100 reads 0", 10'h100, 32'h0);
    rd_chk("R9 write 0x100 left hdr 0x000", 10'h000, 32'hDEAD_BEEF);
    rd_chk("R9 unmapped 0x1CC", 10'h1CC, 32'h0);
    rd_chk("R9 unmapped 0x224", 10'h224, 32'h0);
    rd_chk("R9 unmapped 0x3FC", 10'h3FC, 32'h0);
    wr(10'h1C1, 32'h0BAD_0BAD);
    rd_chk("R9 misaligned write ignored", 10'h1C0, 32'h8000_1234);
    rd_chk("R9 misaligned read 0", 10'h005, 32'h0);
  endtask

  task automatic t_dport();
    logic [31:0] rd; int lat; int base_cnt;
    base_cnt = cfg_count;
    resp_dly = 3;
    access(1'b1, 10'h220, 32'hCAFE_F00D, rd, lat);
    chk("R7 one cfg cycle", 32'(cfg_count - base_cnt), 32'd1);
    chk("R7 cfg addr", cap_addr, 32'h8000_1234);
    chk("R7 cfg we", 32'(cap_we), 32'd1);
    chk("R7 cfg wdata", cap_wdata, 32'hCAFE_F00D);
    chk("R7 stalled ack latency", 32'(lat), 32'd5);
    wr(10'h1C0, 32'h0000_0810);
    resp_dly = 0; resp_data = 32'hA5A5_5A5A;
    access(1'b0, 10'h220, '0, rd, lat);
    chk("R8 read data", rd, 32'hA5A5_5A5A);
    chk("R8 cfg we", 32'(cap_we), 32'd0);
    chk("R8 cfg addr", cap_addr, 32'h0000_0810);
    chk("R8 ack latency", 32'(lat), 32'd2);
    chk("R12 one cycle per access", 32'(cfg_count - base_cnt), 32'd2);
    #1 chk("R12 no request left", 32'(cfg_req), 32'd0);
  endtask

  task automatic t_irq();
    for (int p = 0; p < 16; p += 5) begin
      irq_in = 4'(p); #1;
      chk("R11 irq routing", 32'(irq_out), 32'(p));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 ack low after reset", 32'(cpu_ack), 32'd0);
    chk("R12 cfg_req low after reset", 32'(cfg_req), 32'd0);
    t_reset();
    t_header();
    t_bridge_regs();
    t_xlate();
    t_unmapped();
    t_dport();
    t_irq();
    summary();
  end
endmodule